// File: doc/BRIEF.md
# UART Console Ownership Switch

This block sits between one UART byte interface and two possible users of it: the processor, through a small register port, and an on-chip trace engine that emits a byte stream. Two control characters arriving on the receive side decide which user owns the console. Ctrl-C (0x03) gives the console to the trace engine. The processor is then cut off from the UART, its UART interrupt is masked and it is held in single-step mode. Ctrl-D (0x04) gives the console back and lets the processor run freely again.

Both control characters are removed from the receive stream. While the trace engine owns the console, every other received byte is passed to the processor's step logic as one step pulse. The transmit path changes owner only between bytes, so a byte that has already been handed to the UART is never replaced or cut off.

Top module: `uart_console_switch`

## Requirements
- R1: After reset the processor owns the console. step_en_o is 0, irq_o is 0, tx_valid_o is 0 and the status register (address 1) reads 0.
- R2: A received 0x03 sets step_en_o to 1 from the next clock edge onwards, whatever the current owner.
- R3: While step_en_o is 1, irq_o stays 0 even with a received byte waiting. After returning to processor mode, irq_o is 1 again while that byte is still unread.
- R4: In trace mode the processor is cut off. Received bytes are not stored for it, its writes to address 0 send nothing, and its reads return 0 without clearing the stored byte.
- R5: In trace mode, trc_ready_o is 1 while the transmit stage is empty and owned by the trace engine. A byte offered with trc_valid_i and trc_ready_o is placed on tx_data_o with tx_valid_o at the next edge.
- R6: A received 0x04 clears step_en_o from the next clock edge onwards. If the processor already owns the console, the byte has no other effect.
- R7: Bytes 0x03 and 0x04 are never stored in the processor's receive register, in either mode.
- R8: A byte on tx_valid_o keeps its value and stays valid until it is accepted with tx_ready_i, even if the owner changes meanwhile. The new owner may load a byte only after that.
- R9: In trace mode, each received byte other than 0x04 gives a one-cycle step_pulse_o at the next edge. A 0x04 gives no pulse.
- R10: In processor mode, a received byte other than 0x03 or 0x04 is stored and raises irq_o. A read of address 0 returns the byte and clears the flag. Address 1 reads bit 0 = byte waiting and bit 1 = transmit busy.
- R11: In processor mode, a write to address 0 while transmit is not busy puts the written byte on tx_data_o with tx_valid_o at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte from the UART |
| rx_valid_i | input | 1 | One-cycle strobe for rx_data_i |
| tx_data_o | output | 8 | Byte to the UART transmitter |
| tx_valid_o | output | 1 | tx_data_o holds a byte to send |
| tx_ready_i | input | 1 | Transmitter accepts tx_data_o |
| cpu_sel_i | input | 1 | Register access strobe |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 1 | 0 = data, 1 = status |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data |
| irq_o | output | 1 | Received-byte interrupt to the processor |
| trc_data_i | input | 8 | Byte from the trace engine |
| trc_valid_i | input | 1 | Trace engine offers trc_data_i |
| trc_ready_o | output | 1 | Trace byte is taken this cycle |
| step_en_o | output | 1 | Processor single-step mode |
| step_pulse_o | output | 1 | One step allowed |

## Verification
If the ownership state is wrong, it shows at the ports one edge after the control character arrives. The symptoms are step_en_o, a live irq_o while stepping, or a trace handshake offered to the wrong owner. If the transmit owner switches too early, tx_data_o changes while tx_valid_o is high and unaccepted. That appears in the first cycle after the mode change. If the receive filter is wrong, a control byte lands in the processor's data register, or a missing or extra step pulse appears one edge after the byte.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  typedef enum logic {OWN_CPU = 1'b0, OWN_TRACE = 1'b1} owner_e;
  localparam logic [7:0] KEY_GRAB    = 8'h03;
  localparam logic [7:0] KEY_RELEASE = 8'h04;
endpackage

// File: rtl/ucs_mode_ctl.sv
module ucs_mode_ctl
  import ucs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_valid_i,
  output owner_e        mode_o,
  output logic          step_pulse_o,
  output logic          fwd_valid_o,
  output logic [DW-1:0] fwd_data_o
);
  owner_e mode_q;
  logic   pulse_q;
  logic   is_grab, is_rel;

  assign is_grab = rx_valid_i && (rx_data_i == DW'(KEY_GRAB));
  assign is_rel  = rx_valid_i && (rx_data_i == DW'(KEY_RELEASE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= OWN_CPU;
      pulse_q <= 1'b0;
    end else begin
      if (is_grab)     mode_q <= OWN_TRACE;
      else if (is_rel) mode_q <= OWN_CPU;
      pulse_q <= rx_valid_i && (mode_q == OWN_TRACE) && !is_rel;
    end
  end

  // control characters are swallowed here
  assign fwd_valid_o  = rx_valid_i && (mode_q == OWN_CPU) && !is_grab && !is_rel;
  assign fwd_data_o   = rx_data_i;
  assign mode_o       = mode_q;
  assign step_pulse_o = pulse_q;
endmodule

// File: rtl/ucs_cpu_port.sv
module ucs_cpu_port
  import ucs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  owner_e        mode_i,
  input  logic          fwd_valid_i,
  input  logic [DW-1:0] fwd_data_i,
  input  logic          cpu_sel_i,
  input  logic          cpu_we_i,
  input  logic          cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          tx_busy_i,
  output logic          tx_load_o,
  output logic [DW-1:0] tx_load_data_o,
  output logic          irq_o
);
  logic          rx_full_q;
  logic [DW-1:0] rx_buf_q;
  logic          cpu_on, rd_data;

  assign cpu_on  = (mode_i == OWN_CPU);
  assign rd_data = cpu_sel_i && !cpu_we_i && !cpu_addr_i && cpu_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_full_q <= 1'b0;
      rx_buf_q  <= '0;
    end else if (fwd_valid_i) begin
      rx_full_q <= 1'b1;
      rx_buf_q  <= fwd_data_i;
    end else if (rd_data) begin
      rx_full_q <= 1'b0;
    end
  end

  always_comb begin
    if (!cpu_on)         cpu_rdata_o = '0;
    else if (cpu_addr_i) cpu_rdata_o = {{(DW-2){1'b0}}, tx_busy_i, rx_full_q};
    else                 cpu_rdata_o = rx_buf_q;
  end

  assign tx_load_o      = cpu_sel_i && cpu_we_i && !cpu_addr_i && cpu_on && !tx_busy_i;
  assign tx_load_data_o = cpu_wdata_i;
  assign irq_o          = cpu_on && rx_full_q;
endmodule

// File: rtl/ucs_tx_path.sv
module ucs_tx_path
  import ucs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  owner_e        mode_i,
  input  logic          cpu_load_i,
  input  logic [DW-1:0] cpu_data_i,
  input  logic [DW-1:0] trc_data_i,
  input  logic          trc_valid_i,
  output logic          trc_ready_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic          cpu_busy_o
);
  owner_e        sel_q;
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign trc_ready_o = (sel_q == OWN_TRACE) && (mode_i == OWN_TRACE) && !vld_q;
  assign cpu_busy_o  = vld_q || (sel_q != OWN_CPU);

  // owner follows mode only while the stage is empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= OWN_CPU;
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (vld_q) begin
      if (tx_ready_i) vld_q <= 1'b0;
    end else if (sel_q != mode_i) begin
      sel_q <= mode_i;
    end else if (cpu_load_i) begin
      vld_q <= 1'b1;
      dat_q <= cpu_data_i;
    end else if (trc_valid_i && trc_ready_o) begin
      vld_q <= 1'b1;
      dat_q <= trc_data_i;
    end
  end

  assign tx_data_o  = dat_q;
  assign tx_valid_o = vld_q;
endmodule

// File: rtl/uart_console_switch.sv
module uart_console_switch
  import ucs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_valid_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  input  logic          cpu_sel_i,
  input  logic          cpu_we_i,
  input  logic          cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          irq_o,
  input  logic [DW-1:0] trc_data_i,
  input  logic          trc_valid_i,
  output logic          trc_ready_o,
  output logic          step_en_o,
  output logic          step_pulse_o
);
  owner_e        mode;
  logic          fwd_valid, tx_busy, tx_load;
  logic [DW-1:0] fwd_data, tx_load_data;

  ucs_mode_ctl #(.DW(DW)) u_mode (
    .clk_i, .rst_ni, .rx_data_i, .rx_valid_i,
    .mode_o(mode), .step_pulse_o,
    .fwd_valid_o(fwd_valid), .fwd_data_o(fwd_data)
  );

  ucs_cpu_port #(.DW(DW)) u_cpu (
    .clk_i, .rst_ni, .mode_i(mode),
    .fwd_valid_i(fwd_valid), .fwd_data_i(fwd_data),
    .cpu_sel_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_rdata_o,
    .tx_busy_i(tx_busy), .tx_load_o(tx_load), .tx_load_data_o(tx_load_data),
    .irq_o
  );

  ucs_tx_path #(.DW(DW)) u_tx (
    .clk_i, .rst_ni, .mode_i(mode),
    .cpu_load_i(tx_load), .cpu_data_i(tx_load_data),
    .trc_data_i, .trc_valid_i, .trc_ready_o,
    .tx_data_o, .tx_valid_o, .tx_ready_i,
    .cpu_busy_o(tx_busy)
  );

  assign step_en_o = (mode == OWN_TRACE);
endmodule

// File: rtl/ucs_checker.sv
module ucs_checker #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] rx_data_i,
  input logic          rx_valid_i,
  input logic [DW-1:0] tx_data_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic          irq_o,
  input logic          trc_ready_o,
  input logic          step_en_o,
  input logic          step_pulse_o
);
  a_r2_grab_enters_trace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_data_i == DW'(8'h03) |=> step_en_o);

  a_r6_release_leaves_trace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_data_i == DW'(8'h04) |=> !step_en_o);

  a_r3_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_o |-> !irq_o);

  a_r8_tx_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r5_trace_only_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_ready_o |-> step_en_o && !tx_valid_o);

  a_r9_pulse_in_trace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_pulse_o |-> step_en_o);
endmodule

bind uart_console_switch ucs_checker #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .rx_data_i, .rx_valid_i, .tx_data_o, .tx_valid_o,
  .tx_ready_i, .irq_o, .trc_ready_o, .step_en_o, .step_pulse_o
);

// File: tb/sim_uart_console_switch.sv
module sim_uart_console_switch;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0, cpu_wdata = '0, trc_data = '0;
  logic       rx_valid = 0, tx_ready = 0, cpu_sel = 0, cpu_we = 0, cpu_addr = 0, trc_valid = 0;
  logic [7:0] tx_data, cpu_rdata;
  logic       tx_valid, irq, trc_ready, step_en, step_pulse;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_console_switch u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .cpu_sel_i(cpu_sel), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .irq_o(irq),
    .trc_data_i(trc_data), .trc_valid_i(trc_valid), .trc_ready_o(trc_ready),
    .step_en_o(step_en), .step_pulse_o(step_pulse)
  );

  // {byte, expected step_en, expected step_pulse}
  localparam logic [9:0] VEC [8] = '{
    {8'h41, 1'b0, 1'b0}, {8'h03, 1'b1, 1'b0}, {8'h20, 1'b1, 1'b1}, {8'h03, 1'b1, 1'b1},
    {8'h04, 1'b0, 1'b0}, {8'h04, 1'b0, 1'b0}, {8'h03, 1'b1, 1'b0}, {8'h04, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic cpu_read(input logic a, output logic [7:0] d);
    @(negedge clk); cpu_sel = 1; cpu_we = 0; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk); cpu_sel = 0;
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk); cpu_sel = 1; cpu_we = 1; cpu_addr = 0; cpu_wdata = d;
    @(negedge clk); cpu_sel = 0; cpu_we = 0;
  endtask

  task automatic tx_accept();
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(step_en == 0 && irq == 0 && tx_valid == 0, "R1 reset outputs", {step_en, irq, tx_valid}, 0);
    cpu_read(1'b1, d);
    chk(d == 8'h00, "R1 status", d, 0);

    // table walk: R2 R6 R9
    for (int i = 0; i < 8; i++) begin
      send_rx(VEC[i][9:2]);
      chk(step_en == VEC[i][1], "R2/R6 step_en", step_en, VEC[i][1]);
      chk(step_pulse == VEC[i][0], "R9 step_pulse", step_pulse, VEC[i][0]);
    end
    // R7 R10: only 0x41 stored
    chk(irq == 1, "R10 irq on byte", irq, 1);
    cpu_read(1'b1, d);
    chk(d == 8'h01, "R10 status full", d, 1);
    cpu_read(1'b0, d);
    chk(d == 8'h41, "R7 control bytes not stored", d, 8'h41);
    chk(irq == 0, "R10 irq cleared by read", irq, 0);

    // R3 R4
    send_rx(8'h5A);
    send_rx(8'h03);
    chk(irq == 0, "R3 irq masked", irq, 0);
    cpu_read(1'b0, d);
    chk(d == 8'h00, "R4 read in trace", d, 0);
    cpu_write(8'h55);
    chk(tx_valid == 0, "R4 write ignored", tx_valid, 0);
    send_rx(8'h31);
    send_rx(8'h04);
    chk(irq == 1, "R3 irq restored", irq, 1);
    cpu_read(1'b0, d);
    chk(d == 8'h5A, "R4 byte kept, trace byte not stored", d, 8'h5A);

    // R5 R8
    send_rx(8'h03);
    @(negedge clk); trc_data = 8'h77; trc_valid = 1;
    #1 chk(trc_ready == 1, "R5 trace ready", trc_ready, 1);
    @(negedge clk); trc_valid = 0;
    chk(tx_valid == 1 && tx_data == 8'h77, "R5 trace byte sent", tx_data, 8'h77);
    send_rx(8'h04);
    chk(tx_valid == 1 && tx_data == 8'h77, "R8 byte kept over release", tx_data, 8'h77);
    cpu_read(1'b1, d);
    chk(d == 8'h02, "R8 status busy", d, 2);
    tx_accept();
    @(negedge clk);
    chk(tx_valid == 0, "R8 stage empty", tx_valid, 0);
    cpu_write(8'h42);
    chk(tx_valid == 1 && tx_data == 8'h42, "R11 cpu byte sent", tx_data, 8'h42);
    send_rx(8'h03);
    #1 chk(tx_valid == 1 && tx_data == 8'h42 && trc_ready == 0, "R8 byte kept over grab", tx_data, 8'h42);
    tx_accept();
    @(negedge clk); #1
    chk(trc_ready == 1, "R8 trace owns after boundary", trc_ready, 1);
    send_rx(8'h04);
    chk(step_en == 0, "R6 final release", step_en, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule